// File: doc/BRIEF.md
# Byte-Buffered SPI Master Engine

This block is an SPI master that runs one transfer at a time out of a small byte buffer. Software sets up a mode register and loads buffer slots through a simple register port. A write to the command register then launches the transfer. The command carries four things: the total number of bytes to clock, how many of the leading bytes are driven from the buffer, which of four select outputs to use, and whether that select stays asserted once the transfer ends.

While the transfer runs, each received byte replaces the buffer slot of the byte shifted out in the same position. Bytes past the transmit count are clocked for receive only, with MOSI held low. A held select lets several commands form one framed exchange, for example an opcode, then an address, then a data phase. The `busy` output reports the transfer in progress.

Top module: `spi_byte_master`

## Requirements
- R1: Each SCLK half period lasts D reference clocks, where D is the divider in mode bits [28:16] and a value of 0 counts as 1. Outside a transfer SCLK rests at the level of mode bit 1 (1 = high). During a transfer it leaves that level on odd half periods.
- R2: `busy` rises on the clock edge that accepts a command write (address 1) and stays high for exactly (16*T+1)*D cycles, where T is the total byte count.
- R3: Only the first X bytes are driven from the buffer, where X is the transmit count in command bits [7:4]. Every later bit is driven as 0, and MOSI is 0 whenever no transfer runs.
- R4: Mode bit 3 set shifts each byte least significant bit first. When it is clear, the most significant bit goes first.
- R5: With mode bit 2 clear, bit k appears on MOSI from half period 2k and MISO is sampled at the start of half period 2k+1. With it set, both points move one half period later, so the first clock edge comes half a period after select assertion.
- R6: Command bits [9:8] pick which one of the four `spi_sel` outputs is asserted during a transfer. Its asserted level is high when mode bit 4 is set and low otherwise, and at most one output is ever asserted.
- R7: With command bit 12 set, the select stays asserted after the transfer. With it clear, the select is released on the edge where `busy` falls. Writing the mode register with enable (bit 0) clear releases a held select.
- R8: Buffer slot i sits at address 16+i in data bits [7:0]. After a transfer of T bytes, slots 0..T-1 hold the bytes received on MISO, and later slots keep their contents.
- R9: A command is ignored while enable is clear or while `busy` is high. Writes to the mode register or to buffer slots are also ignored while `busy` is high.
- R10: A total count above 9 is treated as 9. Status at address 2 reads `busy` in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| busy | output | 1 | Transfer in progress |
| sclk | output | 1 | SPI serial clock |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |
| spi_sel | output | 4 | Device selects, polarity set by mode |

## Verification
The checker relies on software changing the mode register only between transfers, since the select polarity and idle level it compares against are read live. It also relies on `miso` being stable for the whole half period before each sampling edge. The stimulus writes mode and buffer contents only while the reference model shows the engine idle, except in the one deliberate test of ignored writes. The bench changes `miso` only on falling reference-clock edges, using the value the model expects for the bit being sampled.

// File: rtl/sbm_pkg.sv
// Shared field widths, register addresses and register layouts for the
// byte-buffered SPI master. Assumes a 5-bit register address space.
package sbm_pkg;
    localparam int DIV_W = 13;
    localparam int CNT_W = 4;
    localparam int SID_W = 2;

    localparam logic [4:0] A_MODE = 5'd0;
    localparam logic [4:0] A_CMD  = 5'd1;
    localparam logic [4:0] A_STAT = 5'd2;
    localparam logic [4:0] A_BUF0 = 5'd16;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             act_high;
        logic             lsb_first;
        logic             late;
        logic             idle_high;
        logic             en;
    } mode_t;

    typedef struct packed {
        logic             hold;
        logic [SID_W-1:0] sel;
        logic [CNT_W-1:0] tx;
        logic [CNT_W-1:0] total;
    } cmd_t;
endpackage

// File: rtl/sbm_regs.sv
// Register file: mode, command, status and the byte buffer.
// Assumes the sequencer's receive write never coincides with a host buffer
// write, which holds because host writes are blocked while busy.
module sbm_regs
    import sbm_pkg::*;
#(
    parameter int MAX_BYTES = 9,
    localparam int IW = $clog2(MAX_BYTES)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_wr,
    input  logic [4:0]     reg_addr,
    input  logic [31:0]    reg_wdata,
    input  logic           busy,
    input  logic           rx_we,
    input  logic [IW-1:0]  rx_idx,
    input  logic [7:0]     rx_data,
    output mode_t          mode,
    output cmd_t           cmd,
    output cmd_t           cmd_nx,
    output logic           start,
    output logic [31:0]    rdata,
    output logic [7:0]     bufm [MAX_BYTES]
);
    logic [CNT_W-1:0] tot_in;

    // Decode a command word, clamping the total count.
    always_comb begin
        tot_in        = reg_wdata[CNT_W-1:0];
        cmd_nx.total  = (tot_in > CNT_W'(MAX_BYTES)) ? CNT_W'(MAX_BYTES) : tot_in;
        cmd_nx.tx     = reg_wdata[7:4];
        cmd_nx.sel    = reg_wdata[9:8];
        cmd_nx.hold   = reg_wdata[12];
    end

    assign start = reg_wr && (reg_addr == A_CMD) && !busy && mode.en;

    // Mode register, frozen while a transfer runs.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode <= '0;
        else if (reg_wr && (reg_addr == A_MODE) && !busy)
            mode <= '{div: reg_wdata[16+DIV_W-1:16], act_high: reg_wdata[4],
                      lsb_first: reg_wdata[3], late: reg_wdata[2],
                      idle_high: reg_wdata[1], en: reg_wdata[0]};
    end

    // Command register, loaded only by an accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmd <= '0;
        else if (start)
            cmd <= cmd_nx;
    end

    for (genvar i = 0; i < MAX_BYTES; i++) begin : g_slot
        // One buffer slot: receive data wins, host writes only when idle.
        always_ff @(posedge clk) begin
            if (!rst_n)
                bufm[i] <= '0;
            else if (rx_we && (rx_idx == IW'(i)))
                bufm[i] <= rx_data;
            else if (reg_wr && !busy && (reg_addr == A_BUF0 + 5'(i)))
                bufm[i] <= reg_wdata[7:0];
        end
    end

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        if (reg_addr == A_MODE)
            rdata = {3'b0, mode.div, 11'b0, mode.act_high, mode.lsb_first,
                     mode.late, mode.idle_high, mode.en};
        else if (reg_addr == A_CMD)
            rdata = {19'b0, cmd.hold, 2'b0, cmd.sel, cmd.tx, cmd.total};
        else if (reg_addr == A_STAT)
            rdata = {31'b0, busy};
        else if (reg_addr >= A_BUF0 && reg_addr < A_BUF0 + 5'(MAX_BYTES))
            rdata = {24'b0, bufm[IW'(reg_addr - A_BUF0)]};
    end
endmodule

// File: rtl/sbm_tick.sv
// Half-period timer: pulses tick on the last reference cycle of each SCLK
// half period. Assumes run rises together with the start of a transfer.
module sbm_tick #(
    parameter int DIV_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] div_eff;

    assign div_eff = (div == '0) ? DIV_W'(1) : div;
    assign tick    = run && (cnt == div_eff - DIV_W'(1));

    // Count reference cycles within the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + DIV_W'(1);
    end
endmodule

// File: rtl/sbm_seq.sv
// Transfer sequencer: walks 16*T+1 half periods, drives MOSI and SCLK,
// samples MISO into a byte shifter and owns the select state.
// Assumes mode and command stay constant while busy.
module sbm_seq
    import sbm_pkg::*;
#(
    parameter int MAX_BYTES = 9,
    parameter int NUM_SEL   = 4,
    localparam int IW = $clog2(MAX_BYTES),
    localparam int HW = $clog2(16*MAX_BYTES+2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  mode_t              mode,
    input  cmd_t               cmd,
    input  cmd_t               cmd_nx,
    input  logic               tick,
    input  logic               miso,
    input  logic [7:0]         bufm [MAX_BYTES],
    output logic               busy,
    output logic               sclk,
    output logic               mosi,
    output logic [NUM_SEL-1:0] sel_pins,
    output logic               rx_we,
    output logic [IW-1:0]      rx_idx,
    output logic [7:0]         rx_data
);
    logic [HW-1:0]      h, hn, last_h, nbits, doff, soff, dk, sk;
    logic               drive_slot, sample_slot, drv_bit, first_bit;
    logic [HW-4:0]      dbyte;
    logic [2:0]         dj;
    logic               cs_on;
    logic [SID_W-1:0]   cs_idx;
    logic [7:0]         rx_sh;

    assign last_h      = HW'(cmd.total) << 4;
    assign nbits       = HW'(cmd.total) << 3;
    assign hn          = h + HW'(1);
    assign doff        = hn - HW'(mode.late);
    assign soff        = hn - HW'(1) - HW'(mode.late);
    assign drive_slot  = (hn >= HW'(mode.late)) && !doff[0];
    assign sample_slot = (hn >= HW'(1) + HW'(mode.late)) && !soff[0];
    assign dk          = doff >> 1;
    assign sk          = soff >> 1;
    assign dbyte       = dk[HW-1:3];
    assign dj          = dk[2:0];

    // Value of the next bit to drive, zero past the transmit count.
    always_comb begin
        drv_bit = 1'b0;
        if (dk < nbits && dbyte < (HW-3)'(cmd.tx) && dbyte < (HW-3)'(MAX_BYTES))
            drv_bit = bufm[IW'(dbyte)][mode.lsb_first ? dj : 3'd7 - dj];
        first_bit = 1'b0;
        if (!mode.late && cmd_nx.tx != '0 && cmd_nx.total != '0)
            first_bit = bufm[0][mode.lsb_first ? 3'd0 : 3'd7];
    end

    assign rx_data = mode.lsb_first ? {miso, rx_sh[7:1]} : {rx_sh[6:0], miso};
    assign rx_we   = busy && tick && (h != last_h) && sample_slot && (sk[2:0] == 3'b111);
    assign rx_idx  = IW'(sk >> 3);

    // Main transfer state: half-period count, data out, receive shifter, select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            h      <= '0;
            mosi   <= 1'b0;
            cs_on  <= 1'b0;
            cs_idx <= '0;
            rx_sh  <= '0;
        end else if (start) begin
            busy   <= 1'b1;
            h      <= '0;
            mosi   <= first_bit;
            cs_on  <= 1'b1;
            cs_idx <= cmd_nx.sel;
        end else if (busy && tick) begin
            if (h == last_h) begin
                busy  <= 1'b0;
                h     <= '0;
                mosi  <= 1'b0;
                cs_on <= cmd.hold;
            end else begin
                h <= hn;
                if (drive_slot)
                    mosi <= drv_bit;
                if (sample_slot)
                    rx_sh <= rx_data;
            end
        end else if (!busy && !mode.en) begin
            cs_on <= 1'b0;
        end
    end

    assign sclk = mode.idle_high ^ (busy & h[0]);

    for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
        assign sel_pins[i] = (cs_on && cs_idx == SID_W'(i)) ? mode.act_high : ~mode.act_high;
    end
endmodule

// File: rtl/spi_byte_master.sv
// Top level of the byte-buffered SPI master: register file, half-period
// timer and transfer sequencer. Assumes one select ID field of SID_W bits.
module spi_byte_master
    import sbm_pkg::*;
#(
    parameter int MAX_BYTES = 9,
    parameter int NUM_SEL   = 4,
    localparam int IW = $clog2(MAX_BYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [4:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               busy,
    output logic               sclk,
    output logic               mosi,
    input  logic               miso,
    output logic [NUM_SEL-1:0] spi_sel
);
    mode_t         mode_q;
    cmd_t          cmd_q, cmd_nx;
    logic          start, tick, rx_we;
    logic [IW-1:0] rx_idx;
    logic [7:0]    rx_data;
    logic [7:0]    bufm [MAX_BYTES];

    sbm_regs #(.MAX_BYTES(MAX_BYTES)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .busy(busy), .rx_we(rx_we), .rx_idx(rx_idx),
        .rx_data(rx_data), .mode(mode_q), .cmd(cmd_q), .cmd_nx(cmd_nx),
        .start(start), .rdata(reg_rdata), .bufm(bufm)
    );

    sbm_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(busy), .div(mode_q.div), .tick(tick)
    );

    sbm_seq #(.MAX_BYTES(MAX_BYTES), .NUM_SEL(NUM_SEL)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode_q), .cmd(cmd_q),
        .cmd_nx(cmd_nx), .tick(tick), .miso(miso), .bufm(bufm), .busy(busy),
        .sclk(sclk), .mosi(mosi), .sel_pins(spi_sel), .rx_we(rx_we),
        .rx_idx(rx_idx), .rx_data(rx_data)
    );
endmodule

// File: rtl/sbm_checker.sv
// Protocol checker for spi_byte_master, attached with bind.
// Assumes mode is only changed while idle.
module sbm_checker
    import sbm_pkg::*;
#(
    parameter int NUM_SEL = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr,
    input logic [4:0]         reg_addr,
    input logic               busy,
    input logic               sclk,
    input logic               mosi,
    input logic               tick,
    input logic [NUM_SEL-1:0] spi_sel,
    input mode_t              mode,
    input cmd_t               cmd
);
    logic [NUM_SEL-1:0] asserted;
    assign asserted = mode.act_high ? spi_sel : ~spi_sel;

    assert_sclk_rest_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk == mode.idle_high));

    assert_sclk_steady_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$past(tick)) |-> $stable(sclk));

    assert_busy_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CMD && !busy && mode.en) |=> busy);

    assert_mosi_rest_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mosi);

    assert_one_sel_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(asserted) <= 1);

    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !cmd.hold) |-> (asserted == '0));

    assert_cmd_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CMD && busy) |=> $stable(cmd));
endmodule

bind spi_byte_master sbm_checker #(.NUM_SEL(NUM_SEL)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .busy(busy), .sclk(sclk), .mosi(mosi), .tick(tick), .spi_sel(spi_sel),
    .mode(mode_q), .cmd(cmd_q)
);

// File: tb/sim_spi_byte_master.sv
module sim_spi_byte_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        busy, sclk, mosi;
    logic        miso = 1'b0;
    logic [3:0]  spi_sel;

    spi_byte_master u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
        .sclk(sclk), .mosi(mosi), .miso(miso), .spi_sel(spi_sel)
    );

    always #10 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit cmp_on = 0, done = 0;
    string tag = "R1";

    // Reference model state
    bit       m_en, m_idle, m_late, m_lsb, m_ah;
    int       m_div;
    bit       mbusy, mcs_on, mhold;
    int       mt, mN, mtx, mD, midx;
    bit [7:0] mbuf [9];
    bit [7:0] mtxb [9];
    bit [7:0] sbyte [9];

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Behavioural reference model, advanced on every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            {m_en, m_idle, m_late, m_lsb, m_ah} = '0;
            m_div = 0; mbusy = 0; mcs_on = 0; mhold = 0;
            mt = 0; mN = 0; mtx = 0; mD = 1; midx = 0;
            for (int i = 0; i < 9; i++) mbuf[i] = 0;
        end else begin
            bit was_busy;
            was_busy = mbusy;
            if (was_busy) begin
                mt++;
                if (mt == (2*8*mN + 1) * mD) begin
                    mbusy = 0;
                    mcs_on = mhold;
                end
            end else if (reg_wr && reg_addr == 5'd1 && m_en) begin
                mN = (reg_wdata[3:0] > 9) ? 9 : int'(reg_wdata[3:0]);
                mtx = int'(reg_wdata[7:4]);
                midx = int'(reg_wdata[9:8]);
                mhold = reg_wdata[12];
                mD = (m_div == 0) ? 1 : m_div;
                for (int i = 0; i < 9; i++) mtxb[i] = mbuf[i];
                for (int i = 0; i < mN; i++) mbuf[i] = sbyte[i];
                mbusy = 1; mt = 0; mcs_on = 1;
            end else if (!m_en) begin
                mcs_on = 0;
            end
            if (reg_wr && !was_busy) begin
                if (reg_addr == 5'd0) begin
                    m_en = reg_wdata[0]; m_idle = reg_wdata[1];
                    m_late = reg_wdata[2]; m_lsb = reg_wdata[3];
                    m_ah = reg_wdata[4]; m_div = int'(reg_wdata[28:16]);
                end else if (reg_addr >= 5'd16 && reg_addr < 5'd25) begin
                    mbuf[reg_addr - 5'd16] = reg_wdata[7:0];
                end
            end
        end
    end

    // Per-cycle comparison and slave MISO drive on falling edges.
    always @(negedge clk) begin
        if (cmp_on) begin
            int h, k;
            bit e_sclk, e_mosi, e_miso;
            logic [3:0] e_sel;
            h = mbusy ? mt / mD : 0;
            e_sclk = m_idle ^ (mbusy && (h % 2 == 1));
            e_mosi = 0; e_miso = 0;
            if (mbusy && h >= int'(m_late)) begin
                k = (h - int'(m_late)) / 2;
                if (k < 8*mN) begin
                    e_miso = sbyte[k/8][m_lsb ? k%8 : 7-k%8];
                    if (k/8 < mtx) e_mosi = mtxb[k/8][m_lsb ? k%8 : 7-k%8];
                end
            end
            for (int i = 0; i < 4; i++)
                e_sel[i] = (mcs_on && midx == i) ? m_ah : !m_ah;
            check(busy == mbusy, {"R2 busy ", tag}, busy, mbusy);
            check(sclk == e_sclk, {"R1 sclk ", tag}, sclk, e_sclk);
            check(mosi == e_mosi, {"R3 mosi ", tag}, mosi, e_mosi);
            check(spi_sel == e_sel, {"R6/R7 sel ", tag}, spi_sel, e_sel);
            miso <= e_miso;
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd_check(input logic [4:0] a, input int exp, input string req);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(reg_rdata == exp, req, reg_rdata, exp);
    endtask

    task automatic wait_idle();
        while (mbusy) @(negedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] mode_w(int div, bit ah, bit lsb, bit late, bit idle, bit en);
        return {3'b0, 13'(div), 11'b0, ah, lsb, late, idle, en};
    endfunction

    function automatic logic [31:0] cmd_w(int tot, int tx, int sel, bit hold);
        return {19'b0, hold, 2'b0, 2'(sel), 4'(tx), 4'(tot)};
    endfunction

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        cmp_on = 1;
        // Reset state: idle low, no select asserted, not busy (R10 status read)
        check(spi_sel == 4'hF, "R6 reset sel", spi_sel, 4'hF);
        rd_check(5'd2, 0, "R10 reset status");

        // R1 R2 R3 R8: MSB first, early phase, divider 2, 2 of 3 bytes driven
        tag = "T1";
        wr(5'd0, mode_w(2, 0, 0, 0, 0, 1));
        wr(5'd16, 32'hA5); wr(5'd17, 32'h3C); wr(5'd18, 32'h0F); wr(5'd19, 32'h77);
        sbyte = '{8'h5A, 8'hC3, 8'h81, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        wr(5'd1, cmd_w(3, 2, 1, 0));
        rd_check(5'd2, 1, "R10 status busy");
        wait_idle();
        rd_check(5'd16, 32'h5A, "R8 slot0");
        rd_check(5'd17, 32'hC3, "R8 slot1");
        rd_check(5'd18, 32'h81, "R8 slot2");
        rd_check(5'd19, 32'h77, "R8 slot3 untouched");

        // R4 R5 R7: LSB first, late select, idle high, divider 1, held select
        tag = "T2";
        wr(5'd0, mode_w(1, 0, 1, 1, 1, 1));
        wr(5'd16, 32'hD2); wr(5'd17, 32'h4B);
        sbyte = '{8'h96, 8'h1E, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        wr(5'd1, cmd_w(2, 2, 2, 1));
        wait_idle();
        check(spi_sel == 4'b1011, "R7 held select", spi_sel, 4'b1011);
        rd_check(5'd16, 32'h96, "R4 lsb slot0");
        // Chained command on the held select, then released
        sbyte = '{8'hE7, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        wr(5'd1, cmd_w(1, 1, 2, 0));
        wait_idle();
        check(spi_sel == 4'hF, "R7 released", spi_sel, 4'hF);
        rd_check(5'd16, 32'hE7, "R5 late slot0");

        // R6: active-high select on output 3, divider 3
        tag = "T3";
        wr(5'd0, mode_w(3, 1, 0, 0, 0, 1));
        wr(5'd16, 32'h69);
        sbyte = '{8'h3B, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        wr(5'd1, cmd_w(1, 1, 3, 0));
        repeat (4) @(negedge clk);
        check(spi_sel == 4'b1000, "R6 active high", spi_sel, 4'b1000);
        wait_idle();

        // R9: writes during busy are ignored
        tag = "T4";
        wr(5'd0, mode_w(4, 0, 0, 0, 0, 1));
        wr(5'd21, 32'h44);
        sbyte = '{8'h12, 8'h34, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        wr(5'd1, cmd_w(2, 2, 0, 0));
        wr(5'd1, cmd_w(1, 1, 3, 1));
        wr(5'd21, 32'hEE);
        wr(5'd0, mode_w(1, 1, 1, 1, 1, 1));
        wait_idle();
        rd_check(5'd21, 32'h44, "R9 slot write ignored");
        rd_check(5'd0, int'(mode_w(4, 0, 0, 0, 0, 1)), "R9 mode write ignored");
        // R7: enable clear releases a held select; R9: no start while disabled
        wr(5'd1, cmd_w(1, 0, 1, 1));
        wait_idle();
        check(spi_sel == 4'b1101, "R7 hold before disable", spi_sel, 4'b1101);
        wr(5'd0, mode_w(4, 0, 0, 0, 0, 0));
        @(negedge clk);
        check(spi_sel == 4'hF, "R7 disable releases", spi_sel, 4'hF);
        wr(5'd1, cmd_w(2, 2, 0, 0));
        check(busy == 0, "R9 disabled command", busy, 0);

        // R10 R1: total 12 clamps to 9, divider 0 acts as 1, all receive-only
        tag = "T5";
        wr(5'd0, mode_w(0, 0, 0, 0, 0, 1));
        for (int i = 0; i < 9; i++) sbyte[i] = 8'(8'h21 * (i + 1));
        wr(5'd1, cmd_w(12, 0, 0, 0));
        wait_idle();
        for (int i = 0; i < 9; i++)
            rd_check(5'(16 + i), int'(sbyte[i]), "R10 clamp slot");

        repeat (3) @(negedge clk);
        finish_up();
    end
endmodule